// File: doc/BRIEF.md
# Scaled Blending Pixel Writer

This block takes a stream of 16-bit pixel words (5 bits each of red, green and blue, with bit 15 as a blend request) and stores them into one of two frame pages held in an external memory. The target position advances automatically after every word. A fractional 11-bit accumulator per axis decides whether a word lands on a new column or row, or is dropped. This lets a sprite be drawn shrunk on a fractional grid. Rows are walked upward: the end of a source row decrements Y and returns X to the saved row start.

Before it stores a word with bit 15 set, the block reads the destination pixel and combines the two. There are three blend modes: additive with saturation, subtractive with a floor at zero, and a three-quarter source mix. A control bit and the low bits of the source's green and blue fields choose the mode. A programmable hotspot raises a sticky collision flag when an unskipped word is aimed at it.

The sequencer has three states. ST_ACCEPT holds ready high. An accepted word that will be stored moves it to ST_READ, and a skipped or off-screen word keeps it in ST_ACCEPT. ST_READ always moves to ST_WRITE, and ST_WRITE always returns to ST_ACCEPT. A stored word therefore takes three cycles and a dropped word takes one.

Top module: `spx_writer`

## Requirements
- R1: After reset, pix_ready is 1, mem_rd and mem_wr are 0 and collide is 0.
- R2: A position write (cfg_sel 2) sets X from cfg_wdata[31:16] and Y from cfg_wdata[15:0], and saves X as the row start. It also clears both skip flags and the column counter, so the next word is drawn at exactly (X, Y).
- R3: A scale write (cfg_sel 1) sets the row modulus from cfg_wdata[15:0] and the step from 0x800 minus cfg_wdata[31:16]. Within a row, each word adds the step to the X accumulator. A carry out of bit 10 advances X and lets the next word draw. No carry makes the next word a skip.
- R4: When the column counter equals the modulus, the counter resets and the step is added to the Y accumulator. On a carry, Y decrements and X reloads the row start.
- R5: A skipped word, or one whose signed X is outside 0..X_VIS-1 or whose signed Y is outside 0..Y_VIS-1, is not written, and pix_ready is 1 again in the cycle after it is accepted.
- R6: A word with bit 15 clear is stored unchanged at address Y*X_VIS+X. mem_wr is high in the second cycle after acceptance, and pix_ready is low for the two cycles in between.
- R7: With bit 15 set and control bit 1 set, each 5-bit channel (blue [4:0], green [9:5], red [14:10]) becomes source plus destination, saturated at 31. The stored bit 15 is 0.
- R8: With bit 15 set, control bit 1 clear and source bits 5 and 0 both 1, each channel becomes destination minus source, floored at 0.
- R9: With bit 15 set, control bit 1 clear and source bits 5 and 0 not both 1, each channel becomes s - (s>>2) + (d>>2).
- R10: A hotspot write (cfg_sel 3) loads hotspot Y when cfg_wdata[14] is 1 and hotspot X otherwise. An unskipped word at X equal to hotspot X and Y equal to hotspot Y[11:0] sets collide. collide stays set until hotspot Y is rewritten.
- R11: Stores go to the page given by control bit 0 (cfg_sel 0, cfg_wdata[0]), and the other page is untouched.
- R12: A blended store asserts mem_rd in the cycle after acceptance and mem_wr in the next cycle at the same address. A plain store never reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 scale/modulus, 2 position, 3 hotspot |
| cfg_wdata | input | 32 | Register write data |
| collide | output | 1 | Sticky hotspot collision flag |
| pix_valid | input | 1 | Pixel word valid |
| pix_data | input | 16 | Pixel word, bit 15 requests blending |
| pix_ready | output | 1 | Block can accept a word |
| mem_rd | output | 1 | Destination read request, data expected one cycle later |
| mem_wr | output | 1 | Pixel store strobe |
| mem_page | output | 1 | Frame page for the access |
| mem_addr | output | AW | Pixel address Y*X_VIS+X |
| mem_rdata | input | 16 | Destination pixel returned by memory |
| mem_wdata | output | 16 | Pixel to store |

## Verification
The bench builds the block with an 8 by 6 visible area, so the frame occupies 48 words per page and both pages fit in a small model memory. With so few columns and rows, the bench can place a word just outside either edge. It can also check that a row wrap and a decrement of Y land on an address computed by hand. It can compare the whole neighbourhood of a scaled run to show that skipped words leave no trace.

// File: rtl/spx_pkg.sv
package spx_pkg;

    typedef enum logic [1:0] {
        ST_ACCEPT = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2
    } spx_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_SCALE = 2'd1;
    localparam logic [1:0] SEL_POS   = 2'd2;
    localparam logic [1:0] SEL_HOT   = 2'd3;

endpackage

// File: rtl/spx_stepper.sv
module spx_stepper #(
    parameter int CW = 16,
    parameter int FW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_pos,
    input  logic [31:0]   pos_data,
    input  logic          load_scale,
    input  logic [31:0]   scale_data,
    input  logic          advance,
    output logic [CW-1:0] x_pos,
    output logic [CW-1:0] y_pos,
    output logic          draw_ok
);
    localparam int SW = 16;
    localparam logic [SW-1:0] UNITY = SW'(1 << FW);

    logic [CW-1:0] x_q, y_q, xs_q;
    logic [SW-1:0] dx_q, mod_q, step_q;
    logic [FW-1:0] accx_q, accy_q;
    logic          skx_q, sky_q;
    logic [SW-1:0] sum_x, sum_y;
    logic          row_end, cx, cy;

    always_comb begin
        sum_x   = SW'(accx_q) + step_q;
        sum_y   = SW'(accy_q) + step_q;
        cx      = sum_x[FW];
        cy      = sum_y[FW];
        row_end = (dx_q == mod_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            xs_q   <= '0;
            dx_q   <= '0;
            mod_q  <= '0;
            step_q <= UNITY;
            accx_q <= '0;
            accy_q <= '0;
            skx_q  <= 1'b0;
            sky_q  <= 1'b0;
        end else begin
            if (load_scale) begin
                mod_q  <= scale_data[15:0];
                step_q <= UNITY - scale_data[31:16];
            end
            if (load_pos) begin
                x_q   <= pos_data[16 +: CW];
                y_q   <= pos_data[0 +: CW];
                xs_q  <= pos_data[16 +: CW];
                skx_q <= 1'b0;
                sky_q <= 1'b0;
                dx_q  <= '0;
            end else if (advance) begin
                if (row_end) begin
                    dx_q   <= '0;
                    accy_q <= sum_y[FW-1:0];
                    if (cy) begin
                        sky_q <= 1'b0;
                        y_q   <= y_q - CW'(1);
                        x_q   <= xs_q;
                    end else begin
                        sky_q <= 1'b1;
                    end
                end else begin
                    dx_q   <= dx_q + SW'(1);
                    accx_q <= sum_x[FW-1:0];
                    if (cx) begin
                        skx_q <= 1'b0;
                        x_q   <= x_q + CW'(1);
                    end else begin
                        skx_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign x_pos   = x_q;
    assign y_pos   = y_q;
    assign draw_ok = !skx_q && !sky_q;

    // R2: a position write lands both coordinates on the next cycle
    a_r2_pos_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_pos |=> (x_pos == $past(pos_data[16 +: CW]) && y_pos == $past(pos_data[0 +: CW]) && draw_ok));

    // R4: a row carry brings X back to the row start
    a_r4_row_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_pos && !load_scale && row_end && cy) |=> (x_pos == xs_q));

endmodule

// File: rtl/spx_blend.sv
module spx_blend #(
    parameter int CHW = 5,
    parameter int NCH = 3,
    localparam int PW = CHW * NCH
) (
    input  logic [PW:0] src,
    input  logic [PW:0] dst,
    input  logic        add_mode,
    output logic [PW:0] result
);
    logic sub_sel;
    assign sub_sel = src[CHW] & src[0];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [CHW-1:0] s, d, mix, sat_add, floor_sub;
        logic [CHW:0]   sum, diff;
        assign s         = src[c*CHW +: CHW];
        assign d         = dst[c*CHW +: CHW];
        assign sum       = {1'b0, s} + {1'b0, d};
        assign diff      = {1'b0, d} - {1'b0, s};
        assign sat_add   = sum[CHW]  ? '1 : sum[CHW-1:0];
        assign floor_sub = diff[CHW] ? '0 : diff[CHW-1:0];
        assign mix       = s - (s >> 2) + (d >> 2);
        assign result[c*CHW +: CHW] = add_mode ? sat_add : (sub_sel ? floor_sub : mix);
    end

    assign result[PW] = 1'b0;

endmodule

// File: rtl/spx_hotspot.sv
module spx_hotspot #(
    parameter int CW = 16,
    parameter int YB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hot_we,
    input  logic [15:0]   hot_wdata,
    input  logic          probe,
    input  logic [CW-1:0] x_pos,
    input  logic [CW-1:0] y_pos,
    output logic          collide
);
    logic [15:0] hx_q, hy_q;
    logic        hy_sel, match;

    assign hy_sel = hot_wdata[14];
    assign match  = probe && (x_pos == hx_q[CW-1:0]) && (y_pos == CW'(hy_q[YB-1:0]));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hx_q <= '0;
            hy_q <= '0;
        end else begin
            if (hot_we && !hy_sel) hx_q <= hot_wdata;
            if (hot_we && hy_sel)  hy_q <= hot_wdata;
            else if (match)        hy_q[15] <= 1'b1;
        end
    end

    assign collide = hy_q[15];

    // R10: the flag holds until hotspot Y is rewritten
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (collide && !(hot_we && hy_sel)) |=> collide);

endmodule

// File: rtl/spx_writer.sv
module spx_writer
    import spx_pkg::*;
#(
    parameter int X_VIS = 320,
    parameter int Y_VIS = 240,
    parameter int CW    = 16,
    parameter int FW    = 11,
    localparam int AW   = $clog2(X_VIS * Y_VIS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic          collide,
    input  logic          pix_valid,
    input  logic [15:0]   pix_data,
    output logic          pix_ready,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_page,
    output logic [AW-1:0] mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   mem_wdata
);
    spx_state_e    state_q, state_d;
    logic [1:0]    ctrl_q;
    logic [15:0]   data_q;
    logic [AW-1:0] addr_q, addr_d;
    logic [CW-1:0] x_pos, y_pos;
    logic          draw_ok, accept, on_screen, store_go;
    logic [15:0]   blended;
    int            xi, yi;

    assign accept = pix_valid && pix_ready;

    spx_stepper #(.CW(CW), .FW(FW)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pos   (cfg_we && cfg_sel == SEL_POS),
        .pos_data   (cfg_wdata),
        .load_scale (cfg_we && cfg_sel == SEL_SCALE),
        .scale_data (cfg_wdata),
        .advance    (accept),
        .x_pos      (x_pos),
        .y_pos      (y_pos),
        .draw_ok    (draw_ok)
    );

    spx_hotspot #(.CW(CW)) u_hot (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_we    (cfg_we && cfg_sel == SEL_HOT),
        .hot_wdata (cfg_wdata[15:0]),
        .probe     (accept && draw_ok),
        .x_pos     (x_pos),
        .y_pos     (y_pos),
        .collide   (collide)
    );

    spx_blend u_blend (
        .src      (data_q),
        .dst      (mem_rdata),
        .add_mode (ctrl_q[1]),
        .result   (blended)
    );

    always_comb begin
        xi        = int'($signed(x_pos));
        yi        = int'($signed(y_pos));
        on_screen = (xi >= 0) && (xi < X_VIS) && (yi >= 0) && (yi < Y_VIS);
        store_go  = draw_ok && on_screen;
        addr_d    = AW'(32'(y_pos) * 32'(X_VIS) + 32'(x_pos));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we && cfg_sel == SEL_CTRL) begin
            ctrl_q <= cfg_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            data_q <= pix_data;
            addr_q <= addr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACCEPT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: if (accept && store_go) state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_ACCEPT;
            default:   state_d = ST_ACCEPT;
        endcase
    end

    always_comb begin
        pix_ready = (state_q == ST_ACCEPT);
        mem_rd    = (state_q == ST_READ) && data_q[15];
        mem_wr    = (state_q == ST_WRITE);
        mem_page  = ctrl_q[0];
        mem_addr  = addr_q;
        mem_wdata = data_q[15] ? blended : data_q;
    end

    // R6: a stored word writes two cycles after it is taken
    a_r6_store_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && store_go) |=> (!pix_ready && !mem_wr) ##1 mem_wr);

    // R5: a dropped word costs one cycle
    a_r5_skip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !store_go) |=> pix_ready);

    // R12: a destination read is followed by the store at the same address
    a_r12_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && $stable(mem_addr)));

    // R6: no new word is taken while a read is outstanding
    a_r6_busy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !pix_ready);

endmodule

// File: tb/sim_spx_writer.sv
module sim_spx_writer;
    localparam int X_VIS = 8;
    localparam int Y_VIS = 6;
    localparam int AW    = $clog2(X_VIS * Y_VIS);
    localparam int NV    = 7;

    // add, src, dst, expected
    localparam logic [48:0] VT [0:NV-1] = '{
        {1'b0, 16'h1234, 16'h7FFF, 16'h1234},
        {1'b1, 16'hD06A, 16'h3C99, 16'h7CFF},
        {1'b0, 16'h8865, 16'h2834, 16'h200F},
        {1'b0, 16'hC104, 16'h23E0, 16'h39A3},
        {1'b0, 16'h8022, 16'h1084, 16'h0443},
        {1'b1, 16'h0ABC, 16'h7FFF, 16'h0ABC},
        {1'b1, 16'h8443, 16'h0421, 16'h0864}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          collide;
    logic          pix_valid = 1'b0;
    logic [15:0]   pix_data = '0;
    logic          pix_ready;
    logic          mem_rd, mem_wr, mem_page;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata = '0;
    logic [15:0]   mem_wdata;

    logic          pre_we = 1'b0;
    logic [AW:0]   pre_addr = '0;
    logic [15:0]   pre_data = '0;
    logic [15:0]   fb [0:(2**(AW+1))-1];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spx_writer #(.X_VIS(X_VIS), .Y_VIS(Y_VIS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .collide(collide), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_ready(pix_ready), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_page(mem_page), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= fb[{mem_page, mem_addr}];
        if (mem_wr) fb[{mem_page, mem_addr}] <= mem_wdata;
        if (pre_we) fb[pre_addr] <= pre_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic preload(input logic [AW:0] a, input logic [15:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        while (!pix_ready) @(negedge clk);
        pix_valid = 1'b1; pix_data = w;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_ready == 1'b1, "R1 ready", 32'(pix_ready), 1);
        chk(!mem_rd && !mem_wr, "R1 idle memory", {mem_rd, mem_wr}, 0);
        chk(collide == 1'b0, "R1 collide", 32'(collide), 0);

        // table: R2 position, R6 plain, R7 add, R8 sub, R9 mix, R11 page
        cfg(2'd1, {16'h0000, 16'hFFFF});
        for (int i = 0; i < NV; i++) begin
            logic pg;
            logic [AW-1:0] a;
            pg = 1'(i % 2);
            a  = AW'(X_VIS + i);
            preload({pg, a}, VT[i][31:16]);
            preload({~pg, a}, 16'h2AAA);
            cfg(2'd0, {30'b0, VT[i][48], pg});
            cfg(2'd2, {16'(i), 16'd1});
            send(VT[i][47:32]);
            settle();
            chk(fb[{pg, a}] == VT[i][15:0], "R2/R6/R7/R8/R9 vector", 32'(fb[{pg, a}]), 32'(VT[i][15:0]));
            chk(fb[{~pg, a}] == 16'h2AAA, "R11 other page", 32'(fb[{~pg, a}]), 32'h2AAA);
        end

        // R6 / R12 timing
        cfg(2'd0, 32'd0);
        cfg(2'd2, {16'd0, 16'd0});
        send(16'h0155);
        chk(!pix_ready, "R6 busy after accept", 32'(pix_ready), 0);
        chk(!mem_rd, "R12 plain no read", 32'(mem_rd), 0);
        @(negedge clk);
        chk(mem_wr && mem_addr == 0 && mem_wdata == 16'h0155, "R6 store cycle", {mem_wr, 10'(mem_addr), mem_wdata}, {1'b1, 10'd0, 16'h0155});
        @(negedge clk);
        chk(pix_ready, "R6 ready again", 32'(pix_ready), 1);
        send(16'h8001);
        chk(mem_rd && mem_addr == 1, "R12 read cycle", {mem_rd, 10'(mem_addr)}, {1'b1, 10'd1});
        @(negedge clk);
        chk(mem_wr && mem_addr == 1, "R12 write follows", {mem_wr, 10'(mem_addr)}, {1'b1, 10'd1});
        settle();

        // R3 scaling with half step
        preload(7'd16, 16'h0); preload(7'd17, 16'h0); preload(7'd18, 16'h0);
        cfg(2'd1, {16'h0400, 16'hFFFF});
        cfg(2'd2, {16'd0, 16'd2});
        send(16'h0111); settle();
        send(16'h0222);
        chk(pix_ready, "R3/R5 skipped word one cycle", 32'(pix_ready), 1);
        settle();
        send(16'h0333); settle();
        chk(fb[16] == 16'h0111, "R3 first drawn", 32'(fb[16]), 32'h0111);
        chk(fb[17] == 16'h0333, "R3 third drawn next column", 32'(fb[17]), 32'h0333);
        chk(fb[18] == 16'h0000, "R3 no extra column", 32'(fb[18]), 0);

        // R4 row wrap with modulus 1
        cfg(2'd1, {16'h0000, 16'h0001});
        cfg(2'd2, {16'd2, 16'd3});
        send(16'h0A01); settle();
        send(16'h0A02); settle();
        send(16'h0A03); settle();
        chk(fb[26] == 16'h0A01, "R4 row start", 32'(fb[26]), 32'h0A01);
        chk(fb[27] == 16'h0A02, "R4 row second", 32'(fb[27]), 32'h0A02);
        chk(fb[18] == 16'h0A03, "R4 next row up", 32'(fb[18]), 32'h0A03);

        // R5 off-screen
        cfg(2'd1, {16'h0000, 16'hFFFF});
        preload(7'd32, 16'h0);
        cfg(2'd2, {16'hFFFF, 16'd4});
        send(16'h0777);
        chk(pix_ready, "R5 left edge one cycle", 32'(pix_ready), 1);
        settle();
        chk(fb[32] == 16'h0000, "R5 left edge not stored", 32'(fb[32]), 0);
        send(16'h0888); settle();
        chk(fb[32] == 16'h0888, "R5 column zero stored", 32'(fb[32]), 32'h0888);
        cfg(2'd2, {16'd1, 16'(Y_VIS)});
        send(16'h0999);
        chk(pix_ready && !mem_rd, "R5 bottom edge one cycle", {pix_ready, mem_rd}, 2);

        // R10 hotspot
        cfg(2'd3, 32'h0000_0005);
        cfg(2'd3, 32'h0000_4002);
        chk(collide == 1'b0, "R10 cleared by Y write", 32'(collide), 0);
        cfg(2'd2, {16'd4, 16'd2});
        send(16'h0001);
        chk(collide == 1'b0, "R10 miss", 32'(collide), 0);
        settle();
        send(16'h0002);
        chk(collide == 1'b1, "R10 hit", 32'(collide), 1);
        settle();
        cfg(2'd3, 32'h0000_0006);
        chk(collide == 1'b1, "R10 X write keeps flag", 32'(collide), 1);
        cfg(2'd3, 32'h0000_4002);
        chk(collide == 1'b0, "R10 Y write clears flag", 32'(collide), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule